// File: doc/BRIEF.md
# Two-Page Split State Machine with Token Hand-Off

This block runs one four-state controller that has been cut across two pages. The first page holds the global states A and B, and the second page holds C and D. Each page also has an idle holding state. A page sits in that state whenever control is elsewhere, and it does nothing there except watch its incoming activation stream. Only one page runs at any moment. The running page advances on a step request. When the requested target lies in the same page, the move is local. When the target lies in the other page, the running page emits one activation token and goes idle.

Both activation paths from one page to the other are merged onto a single stream. The token names the entry state inside the receiving page as a one-bit code. Each stream is a fixed-length register pipeline that models the unknown inter-page wire delay. Its length is the parameter `LINK_DEPTH`. The idle state of each page has one firing rule for each state of the other page. These rules are not ordered, yet the result stays deterministic because only one sender can ever be live. Each page keeps a small work counter that stands in for its data path. A sticky flag reports any cycle in which both pages were running.

Top module: `split_fsm_pair`

## Requirements
- R1: After reset the A/B page is running in state A. The C/D page is idle. `active_o` is 01, `state_o` is 0, both work counters are 0 and `err_o` is 0.
- R2: `dir_i` codes the global target: 0=A, 1=B, 2=C, 3=D. Bit 1 selects the page (0 = A/B page, 1 = C/D page). With `step_i` high and a target in the running page, `state_o` equals the target one cycle later.
- R3: With `step_i` high and a target in the other page, the sender is idle one cycle later. `active_o` then stays 00 for exactly `LINK_DEPTH` cycles. The receiver is running in the target state `LINK_DEPTH`+1 cycles after the step.
- R4: The token carries bit 0 of `dir_i` as the entry code: 0 enters the first state of the page (A or C) and 1 enters the second (B or D). The idle state accepts a token sent from either state of the other page.
- R5: `active_o` is never 11.
- R6: `step_i` and `dir_i` have no effect while no page is running. The hand-off completes to the original target.
- R7: With `step_i` low, or with `dir_i` equal to the current state, the running state is unchanged.
- R8: The work counter of a page grows by one for every cycle the page is running. It holds while the page is idle and wraps modulo 2^`CNT_W`.
- R9: `err_o` is a sticky flag that is set if both pages are ever running together. In correct operation it stays 0.
- R10: `state_o` shows the global code of the running state, and 0 when no page is running. `active_o` bit 0 marks the A/B page as running and bit 1 marks the C/D page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Request to move to the state coded on dir_i |
| dir_i | input | 2 | Global target state code (0=A, 1=B, 2=C, 3=D) |
| active_o | output | 2 | Running flags: bit 0 for the A/B page, bit 1 for the C/D page |
| state_o | output | 2 | Global code of the running state, 0 when none |
| work_ab_o | output | CNT_W | Work counter of the A/B page |
| work_cd_o | output | CNT_W | Work counter of the C/D page |
| err_o | output | 1 | Sticky flag for both pages running together |

## Verification
A move inside a page and the sender going idle are both visible one cycle after the step. A cross-page move keeps both running flags low for `LINK_DEPTH` cycles and shows the receiver running at `LINK_DEPTH`+1 cycles. Each work counter changes one cycle after a running cycle. The bench applies inputs after a falling edge and advances its arithmetic model at the rising edge. It compares every output at the following falling edge, so each result is sampled in the cycle it is due. The sweep covers every ordered pair of source and target states. It also drives step requests during each transit, to show that they are ignored.

// File: rtl/split_fsm_pkg.sv
package split_fsm_pkg;

    // Local state of one page controller.
    typedef enum logic [1:0] {
        PG_IDLE  = 2'd0,
        PG_FIRST = 2'd1,
        PG_SECOND = 2'd2
    } pg_state_e;

    // Activation token: valid plus one-bit entry code.
    typedef struct packed {
        logic vld;
        logic code;
    } act_tok_t;

endpackage

// File: rtl/act_link.sv
module act_link
    import split_fsm_pkg::*;
#(
    parameter int LINK_DEPTH = 3
) (
    input  logic     clk_i,
    input  logic     rst_ni,
    input  act_tok_t push_i,
    output act_tok_t head_o
);

    act_tok_t stg_d [LINK_DEPTH];
    act_tok_t stg_q [LINK_DEPTH];

    always_comb begin
        stg_d[0] = push_i;
        for (int k = 1; k < LINK_DEPTH; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int k = 0; k < LINK_DEPTH; k++) begin
            if (!rst_ni) begin
                stg_q[k] <= '0;
            end else begin
                stg_q[k] <= stg_d[k];
            end
        end
    end

    assign head_o = stg_q[LINK_DEPTH-1];

endmodule

// File: rtl/page_ctrl.sv
module page_ctrl
    import split_fsm_pkg::*;
#(
    parameter bit PAGE_BIT     = 1'b0,
    parameter bit START_ACTIVE = 1'b1,
    parameter int CNT_W        = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [1:0]       dir_i,
    input  act_tok_t         tok_in_i,
    output act_tok_t         tok_out_o,
    output logic             active_o,
    output logic             local_o,
    output logic [CNT_W-1:0] work_o
);

    typedef struct packed {
        pg_state_e        st;
        logic [CNT_W-1:0] work;
    } pg_regs_t;

    localparam pg_state_e RST_ST = START_ACTIVE ? PG_FIRST : PG_IDLE;

    pg_regs_t r_d, r_q;
    act_tok_t tok_d;

    always_comb begin
        r_d   = r_q;
        tok_d = '0;
        unique case (r_q.st)
            PG_IDLE: begin
                // one firing rule per activator; the merged stream carries only the entry code
                if (tok_in_i.vld) begin
                    r_d.st = tok_in_i.code ? PG_SECOND : PG_FIRST;
                end
            end
            PG_FIRST, PG_SECOND: begin
                r_d.work = r_q.work + 1'b1;
                if (step_i) begin
                    if (dir_i[1] == PAGE_BIT) begin
                        r_d.st = dir_i[0] ? PG_SECOND : PG_FIRST;
                    end else begin
                        tok_d.vld  = 1'b1;
                        tok_d.code = dir_i[0];
                        r_d.st     = PG_IDLE;
                    end
                end
            end
            default: r_d.st = PG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.st   <= RST_ST;
            r_q.work <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tok_out_o = tok_d;
    assign active_o  = (r_q.st != PG_IDLE);
    assign local_o   = (r_q.st == PG_SECOND);
    assign work_o    = r_q.work;

endmodule

// File: rtl/split_fsm_pair.sv
module split_fsm_pair
    import split_fsm_pkg::*;
#(
    parameter int LINK_DEPTH = 3,
    parameter int CNT_W      = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [1:0]       dir_i,
    output logic [1:0]       active_o,
    output logic [1:0]       state_o,
    output logic [CNT_W-1:0] work_ab_o,
    output logic [CNT_W-1:0] work_cd_o,
    output logic             err_o
);

    act_tok_t tok_ab2cd_push, tok_ab2cd_head;
    act_tok_t tok_cd2ab_push, tok_cd2ab_head;
    logic     run_ab, run_cd, loc_ab, loc_cd;
    logic     err_d, err_q;

    page_ctrl #(.PAGE_BIT(1'b0), .START_ACTIVE(1'b1), .CNT_W(CNT_W)) u_page_ab (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
        .tok_in_i(tok_cd2ab_head), .tok_out_o(tok_ab2cd_push),
        .active_o(run_ab), .local_o(loc_ab), .work_o(work_ab_o)
    );

    page_ctrl #(.PAGE_BIT(1'b1), .START_ACTIVE(1'b0), .CNT_W(CNT_W)) u_page_cd (
        .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .dir_i(dir_i),
        .tok_in_i(tok_ab2cd_head), .tok_out_o(tok_cd2ab_push),
        .active_o(run_cd), .local_o(loc_cd), .work_o(work_cd_o)
    );

    act_link #(.LINK_DEPTH(LINK_DEPTH)) u_link_ab2cd (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tok_ab2cd_push), .head_o(tok_ab2cd_head)
    );

    act_link #(.LINK_DEPTH(LINK_DEPTH)) u_link_cd2ab (
        .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tok_cd2ab_push), .head_o(tok_cd2ab_head)
    );

    always_comb begin
        err_d = err_q | (run_ab & run_cd);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= err_d;
    end

    always_comb begin
        if (run_ab)      state_o = {1'b0, loc_ab};
        else if (run_cd) state_o = {1'b1, loc_cd};
        else             state_o = 2'd0;
    end

    assign active_o = {run_cd, run_ab};
    assign err_o    = err_q;

endmodule

// File: rtl/split_fsm_pair_chk.sv
module split_fsm_pair_chk
    import split_fsm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       active_o,
    input logic [CNT_W-1:0] work_ab_o,
    input logic [CNT_W-1:0] work_cd_o,
    input logic             err_o,
    input act_tok_t         tok_ab2cd_push,
    input act_tok_t         tok_ab2cd_head,
    input act_tok_t         tok_cd2ab_push,
    input act_tok_t         tok_cd2ab_head
);

    // R5
    one_page_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(active_o[0] && active_o[1]));

    // R9
    no_overlap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !err_o);

    // R3
    token_meets_idle_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_cd2ab_head.vld |-> !active_o[0]);

    // R3
    token_meets_idle_cd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tok_ab2cd_head.vld |-> !active_o[1]);

    // R3
    wake_ab_by_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o[0]) |-> $past(tok_cd2ab_head.vld));

    // R3
    wake_cd_by_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o[1]) |-> $past(tok_ab2cd_head.vld));

    // R3
    handoff_ab_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(active_o[0]) |-> $past(tok_ab2cd_push.vld));

    // R8
    work_ab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o[0] |=> $stable(work_ab_o));

    // R8
    work_cd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o[1] |=> work_cd_o == $past(work_cd_o) + 1'b1);

endmodule

bind split_fsm_pair split_fsm_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_o(active_o),
    .work_ab_o(work_ab_o), .work_cd_o(work_cd_o), .err_o(err_o),
    .tok_ab2cd_push(tok_ab2cd_push), .tok_ab2cd_head(tok_ab2cd_head),
    .tok_cd2ab_push(tok_cd2ab_push), .tok_cd2ab_head(tok_cd2ab_head)
);

// File: tb/split_fsm_pair_bench.sv
module split_fsm_pair_bench;

    localparam int L  = 3;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_i = 1'b0;
    logic [1:0]    dir_i = 2'd0;
    logic [1:0]    active_o, state_o;
    logic [CW-1:0] work_ab_o, work_cd_o;
    logic          err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // spec model
    bit            m_act;
    logic [1:0]    m_cur;
    logic [1:0]    m_pend;
    int            m_rem;
    logic [CW-1:0] m_wab, m_wcd;

    always #5 clk = ~clk;

    split_fsm_pair #(.LINK_DEPTH(L), .CNT_W(CW)) u_split_fsm_pair (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step_i), .dir_i(dir_i),
        .active_o(active_o), .state_o(state_o),
        .work_ab_o(work_ab_o), .work_cd_o(work_cd_o), .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [1:0] ea;
        ea = m_act ? (m_cur[1] ? 2'b10 : 2'b01) : 2'b00;
        chk("R3/R5 active_o", 32'(active_o), 32'(ea));
        chk("R2/R4/R10 state_o", 32'(state_o), m_act ? 32'(m_cur) : 32'd0);
        chk("R8 work_ab_o", 32'(work_ab_o), 32'(m_wab));
        chk("R8 work_cd_o", 32'(work_cd_o), 32'(m_wcd));
        chk("R9 err_o", 32'(err_o), 32'd0);
    endtask

    task automatic tick(input logic s, input logic [1:0] d);
        step_i = s;
        dir_i  = d;
        @(posedge clk);
        if (m_act) begin
            if (m_cur[1]) m_wcd = m_wcd + 1'b1;
            else          m_wab = m_wab + 1'b1;
            if (s) begin
                if (d[1] == m_cur[1]) begin
                    m_cur = d;
                end else begin
                    m_act  = 1'b0;
                    m_rem  = L;
                    m_pend = d;
                end
            end
        end else if (m_rem == 1) begin
            m_act = 1'b1;
            m_cur = m_pend;
        end else begin
            m_rem--;
        end
        @(negedge clk);
        compare_all();
    endtask

    // request a move, then keep stepping with a decoy target during transit (R6)
    task automatic move_to(input logic [1:0] t);
        tick(1'b1, t);
        while (!m_act) tick(1'b1, ~t);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_act = 1'b1; m_cur = 2'd0; m_pend = 2'd0; m_rem = 0;
        m_wab = '0; m_wcd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 active_o", 32'(active_o), 32'd1);
        chk("R1 state_o", 32'(state_o), 32'd0);
        chk("R1 work_ab_o", 32'(work_ab_o), 32'd0);
        chk("R1 work_cd_o", 32'(work_cd_o), 32'd0);
        chk("R1 err_o", 32'(err_o), 32'd0);

        // R7 hold with step_i low for several target codes
        for (int k = 0; k < 4; k++) tick(1'b0, 2'(k));

        // sweep every ordered pair: R2, R3, R4, R6, R7, R8
        for (int f = 0; f < 4; f++) begin
            for (int t = 0; t < 4; t++) begin
                if (m_cur != 2'(f)) move_to(2'(f));
                tick(1'b0, 2'(3 - f));   // R7 step low
                tick(1'b1, 2'(f));       // R7 self target
                move_to(2'(t));          // R2 local or R3/R4 cross, R6 decoys
                tick(1'b0, 2'(f));
            end
        end

        // R3 exact idle window length after a cross move from B to D
        move_to(2'd1);
        tick(1'b1, 2'd3);
        for (int k = 0; k < L; k++) begin
            chk("R3 idle window", 32'(active_o), 32'd0);
            if (k < L - 1) tick(1'b0, 2'd0);
            else           tick(1'b1, 2'd1);   // R6 ignored on last transit cycle
        end
        chk("R3/R4 landed in D", 32'(state_o), 32'd3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule